// File: doc/BRIEF.md
# General-Purpose Output/Input Port Register Block

This block is the software-visible register set of one 32-pin general-purpose I/O port. It holds the value driven onto the output pins. It also offers three write-only mask registers, each of which forces the selected output bits high, forces them low or flips them in a single bus write. Because of these masks, software never needs a read-modify-write sequence to change a few pins. A read-only register shows the pin levels after a two-flop synchronizer.

The block sits on a simple single-cycle peripheral bus. A write takes effect at the clock edge that ends the write-strobe cycle. Read data and the error flag are combinational during the cycle the strobe is high, and both are zero when no strobe is present. The port decodes a 64-byte window. An access above that window, or to a byte address that is not word aligned, raises the error flag and changes nothing.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the output pins are all zero, and a read of the output data register (byte offset 0x00) returns zero.
- R2: A write to offset 0x00 loads the written word onto the output pins at the next clock edge. A read of offset 0x00 returns the current output word.
- R3: A write to offset 0x04 drives high every output bit whose written bit is 1, and leaves the others unchanged. A read of offset 0x04 returns zero.
- R4: A write to offset 0x08 drives low every output bit whose written bit is 1, and leaves the others unchanged. A read of offset 0x08 returns zero.
- R5: A write to offset 0x0C inverts every output bit whose written bit is 1, and leaves the others unchanged. A read of offset 0x0C returns zero.
- R6: A read of offset 0x10 returns the pin inputs as they were two clock edges earlier. A write to offset 0x10 changes nothing and raises no error.
- R7: Word-aligned offsets 0x14 to 0x3C read as zero. Writes to them change nothing, and neither reads nor writes raise an error.
- R8: A read or write at a byte address of 0x40 or above raises the error flag in the same cycle. Such a read returns zero and such a write changes nothing.
- R9: A read or write whose address has either of the two low bits set raises the error flag. Such a read returns zero and such a write changes nothing.
- R10: In a cycle with neither strobe asserted, the error flag is low and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busAddr | input | 8 | Byte address of the access |
| busWdata | input | 32 | Write data or bit mask |
| busRdata | output | 32 | Read data, valid while busRdEn is high |
| busErr | output | 1 | Access error, valid while a strobe is high |
| pinIn | input | 32 | Asynchronous pin levels |
| pinOut | output | 32 | Output pin values |

## Verification
The checker tests every cycle for the following: the set, clear and toggle effects of a write at the next edge; that the mask registers read as zero; that the error flag appears for out-of-window and misaligned accesses; that errored writes and writes to the input register leave the pins stable; and that the bus is quiet when no strobe is present. Only the bench's scenarios show the following: the exact values the output word takes through a chain of mask writes; the two-edge delay of the input synchronizer; that the reserved offsets inside the window read as zero without error; and that an assertion of reset during operation returns the pins to zero.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Word index (byte offset / 4) of each register inside the window
  localparam int unsigned IDX_OUT = 0;
  localparam int unsigned IDX_SET = 1;
  localparam int unsigned IDX_CLR = 2;
  localparam int unsigned IDX_TGL = 3;
  localparam int unsigned IDX_IN  = 4;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_OUT  = 2'd1,
    RD_IN   = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   wrOut;
    logic   wrSet;
    logic   wrClr;
    logic   wrTgl;
    rdSel_e rdSel;
    logic   err;
  } portStrobes_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned WIN_BYTES = 64
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output portStrobes_t      strb
);

  localparam int unsigned WIN_AW = $clog2(WIN_BYTES);
  localparam int unsigned IDX_W  = WIN_AW - 2;

  logic             inWindow;
  logic             aligned;
  logic             access;
  logic             goodAcc;
  logic [IDX_W-1:0] wordIdx;

  generate
    if (ADDR_W > WIN_AW) begin : g_upper
      assign inWindow = ~|busAddr[ADDR_W-1:WIN_AW];
    end else begin : g_full
      assign inWindow = 1'b1;
    end
  endgenerate

  assign aligned = (busAddr[1:0] == 2'b00);
  assign access  = busWrEn | busRdEn;
  assign goodAcc = inWindow & aligned;
  assign wordIdx = busAddr[WIN_AW-1:2];

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_ZERO;
    strb.err   = access & ~goodAcc;
    if (goodAcc && busWrEn) begin
      strb.wrOut = (wordIdx == IDX_W'(IDX_OUT));
      strb.wrSet = (wordIdx == IDX_W'(IDX_SET));
      strb.wrClr = (wordIdx == IDX_W'(IDX_CLR));
      strb.wrTgl = (wordIdx == IDX_W'(IDX_TGL));
    end
    if (goodAcc && busRdEn) begin
      if (wordIdx == IDX_W'(IDX_OUT))     strb.rdSel = RD_OUT;
      else if (wordIdx == IDX_W'(IDX_IN)) strb.rdSel = RD_IN;
      else                                strb.rdSel = RD_ZERO;
    end
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobes_t      strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] pinOut
);

  logic [DATA_W-1:0] outQ;
  logic [DATA_W-1:0] outNext;
  logic [DATA_W-1:0] syncQ [SYNC_STAGES];

  always_comb begin
    outNext = outQ;
    if (strb.wrOut)      outNext = busWdata;
    else if (strb.wrSet) outNext = outQ | busWdata;
    else if (strb.wrClr) outNext = outQ & ~busWdata;
    else if (strb.wrTgl) outNext = outQ ^ busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outQ <= '0;
    else       outQ <= outNext;
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= '0;
          else       syncQ[s] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= '0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  always_comb begin
    unique case (strb.rdSel)
      RD_OUT:  busRdata = outQ;
      RD_IN:   busRdata = syncQ[SYNC_STAGES-1];
      default: busRdata = '0;
    endcase
  end

  assign pinOut = outQ;

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned WIN_BYTES   = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOut
);

  portStrobes_t strb;

  gpio_port_ctrl #(
    .ADDR_W   (ADDR_W),
    .WIN_BYTES(WIN_BYTES)
  ) ctrl_i (
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .busAddr(busAddr),
    .strb   (strb)
  );

  gpio_port_datapath #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busWdata(busWdata),
    .pinIn   (pinIn),
    .busRdata(busRdata),
    .pinOut  (pinOut)
  );

  assign busErr = strb.err;

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WIN_BYTES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              busErr,
  input logic [DATA_W-1:0] pinOut
);

  logic access;
  logic isAlias;
  logic isOut;
  logic isIn;
  logic beyond;
  logic misal;

  assign access  = busWrEn | busRdEn;
  assign isOut   = (busAddr == ADDR_W'('h00));
  assign isIn    = (busAddr == ADDR_W'('h10));
  assign isAlias = (busAddr == ADDR_W'('h04)) || (busAddr == ADDR_W'('h08)) ||
                   (busAddr == ADDR_W'('h0C));
  assign beyond  = (32'(busAddr) >= WIN_BYTES);
  assign misal   = (busAddr[1:0] != 2'b00);

  AST_ALIAS_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && isAlias |-> busRdata == '0); // R3

  AST_SET_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && !busRdEn && busAddr == ADDR_W'('h04)
      |=> (pinOut & $past(busWdata)) == $past(busWdata)); // R3

  AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && !busRdEn && busAddr == ADDR_W'('h08)
      |=> (pinOut & $past(busWdata)) == '0); // R4

  AST_TGL_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && !busRdEn && busAddr == ADDR_W'('h0C)
      |=> pinOut == ($past(pinOut) ^ $past(busWdata))); // R5

  AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && isOut |=> pinOut == $past(busWdata)); // R2

  AST_IN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && isIn |=> $stable(pinOut)); // R6

  AST_IN_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    access && isIn |-> !busErr); // R6

  AST_BEYOND_ERR: assert property (@(posedge clk) disable iff (!rstN)
    access && beyond |-> busErr); // R8

  AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rstN)
    access && misal |-> busErr); // R9

  AST_ERR_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busErr |=> $stable(pinOut)); // R8

  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && busErr |-> busRdata == '0); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !access |-> !busErr && busRdata == '0); // R10

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .WIN_BYTES(WIN_BYTES)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busWrEn (busWrEn),
  .busRdEn (busRdEn),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .busErr  (busErr),
  .pinOut  (pinOut)
);

// File: tb/gpio_port_regs_tb_top.sv
module gpio_port_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic        isRead;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] expVal;  // read data for reads, pinOut after edge for writes
    logic        expErr;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h00, 32'h1234_5678, 32'h1234_5678, 1'b0, 8'd2},  // R2 load
    '{1'b1, 8'h00, 32'h0,         32'h1234_5678, 1'b0, 8'd2},  // R2 read back
    '{1'b0, 8'h04, 32'h0000_FFFF, 32'h1234_FFFF, 1'b0, 8'd3},  // R3 set
    '{1'b1, 8'h04, 32'h0,         32'h0,         1'b0, 8'd3},  // R3 reads zero
    '{1'b0, 8'h08, 32'hFF00_00F0, 32'h0034_FF0F, 1'b0, 8'd4},  // R4 clear
    '{1'b1, 8'h08, 32'h0,         32'h0,         1'b0, 8'd4},  // R4 reads zero
    '{1'b0, 8'h0C, 32'h0F0F_0F0F, 32'h0F3B_F000, 1'b0, 8'd5},  // R5 toggle
    '{1'b1, 8'h0C, 32'h0,         32'h0,         1'b0, 8'd5},  // R5 reads zero
    '{1'b0, 8'h10, 32'hFFFF_FFFF, 32'h0F3B_F000, 1'b0, 8'd6},  // R6 write ignored
    '{1'b1, 8'h10, 32'h0,         32'hA5A5_0F0F, 1'b0, 8'd6},  // R6 input read
    '{1'b0, 8'h14, 32'hFFFF_FFFF, 32'h0F3B_F000, 1'b0, 8'd7},  // R7 reserved write
    '{1'b1, 8'h3C, 32'h0,         32'h0,         1'b0, 8'd7},  // R7 reserved read
    '{1'b0, 8'h40, 32'hFFFF_FFFF, 32'h0F3B_F000, 1'b1, 8'd8},  // R8 beyond window write
    '{1'b1, 8'h80, 32'h0,         32'h0,         1'b1, 8'd8},  // R8 beyond window read
    '{1'b0, 8'h06, 32'hFFFF_FFFF, 32'h0F3B_F000, 1'b1, 8'd9},  // R9 misaligned write
    '{1'b1, 8'h01, 32'h0,         32'h0,         1'b1, 8'd9},  // R9 misaligned read
    '{1'b0, 8'h04, 32'h0000_0000, 32'h0F3B_F000, 1'b0, 8'd3}   // R3 zero mask
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_regs dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .busErr  (busErr),
    .pinIn   (pinIn),
    .pinOut  (pinOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one access after a falling edge, sample the combinational response,
  // then check pinOut one time step after the rising edge.
  task automatic busOp(input logic rd, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] rdat, output logic err, output logic [31:0] outAfter);
    @(negedge clk);
    busRdEn  = rd;
    busWrEn  = ~rd;
    busAddr  = a;
    busWdata = d;
    #1;
    rdat = busRdata;
    err  = busErr;
    @(posedge clk);
    #1;
    outAfter = pinOut;
    busRdEn  = 1'b0;
    busWrEn  = 1'b0;
  endtask

  initial begin
    logic [31:0] rdat;
    logic        err;
    logic [31:0] outAfter;

    // R1: reset state
    #(3*CLK_PERIOD);
    check("R1 pinOut in reset", pinOut, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    busOp(1'b1, 8'h00, 32'h0, rdat, err, outAfter);
    check("R1 read out after reset", rdat, 32'h0);
    check("R1 pinOut after reset", outAfter, 32'h0);

    // R10: idle bus is quiet
    @(negedge clk);
    #1;
    check("R10 idle err", 32'(busErr), 32'h0);
    check("R10 idle rdata", busRdata, 32'h0);

    // settle inputs for the table's R6 read
    pinIn = 32'hA5A5_0F0F;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      busOp(VECS[i].isRead, VECS[i].addr, VECS[i].data, rdat, err, outAfter);
      check({tag, " err"}, 32'(err), 32'(VECS[i].expErr));
      if (VECS[i].isRead) check({tag, " rdata"}, rdat, VECS[i].expVal);
      else                check({tag, " pinOut"}, outAfter, VECS[i].expVal);
    end

    // R6: two-edge synchronizer latency
    @(negedge clk);
    pinIn    = 32'h3C3C_C3C3;
    busRdEn  = 1'b1;
    busAddr  = 8'h10;
    #1;
    check("R6 latency 0 edges", busRdata, 32'hA5A5_0F0F);
    @(negedge clk);
    #1;
    check("R6 latency 1 edge", busRdata, 32'hA5A5_0F0F);
    @(negedge clk);
    #1;
    check("R6 latency 2 edges", busRdata, 32'h3C3C_C3C3);
    busRdEn = 1'b0;

    // R2: overwrite whole word
    busOp(1'b0, 8'h00, 32'hDEAD_BEEF, rdat, err, outAfter);
    check("R2 overwrite", outAfter, 32'hDEAD_BEEF);

    // R1: reset during operation clears pins
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 mid-run reset", pinOut, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule